// File: doc/BRIEF.md
# Two-Slot Receive Frame Store with Overrun Flag

This block holds completed receive frames between a bit-level receive engine and a CPU register interface. The engine sends three single-cycle pulses: frame start, frame valid and frame abort. The whole frame (identifier, extended-format flag, remote flag, length code and eight data bytes) sits on a parallel bus and is taken in on the valid pulse. The store has two slots and always presents the oldest unreleased frame on its output fields. A "frame available" flag stays high for as long as any frame is held.

The CPU reads the presented frame and then pulses a release command. Release frees the slot. If a second frame is waiting, it appears on the outputs at once and the available flag stays high. The available flag drops only when the last frame is released.

The ingress side has no back-pressure. The engine never waits, and the store has no ready signal. A frame that completes while both slots are full is discarded, and a sticky overrun flag is raised. An aborted frame is never stored and never raises overrun. The overrun flag clears only on its own clear command or on reset.

Top module: `rxbuf_dual`

## Requirements
- R1: After reset, `rx_avail`, `overrun` and `rx_active` are all 0, and both slots are empty.
- R2: A valid pulse into a non-full store captures the frame bus. From the next cycle `rx_avail` is 1, and if the store was empty the frame appears on the `out_*` fields.
- R3: Frames are presented oldest first. Releasing the head while a second frame is held presents the second frame on the next cycle, and `rx_avail` stays 1.
- R4: Releasing the only held frame makes `rx_avail` 0 on the next cycle.
- R5: A valid pulse while both slots are held and no release comes in the same cycle drops the frame. `overrun` is 1 from the next cycle, and the two held frames are kept unchanged and in order.
- R6: An abort pulse stores nothing and never sets `overrun`, even when both slots are full. The abort also ends the frame in progress.
- R7: `overrun` stays 1 until a `cpu_clr_overrun` pulse, which makes it 0 on the next cycle. If a drop happens in the same cycle as a clear, the set wins.
- R8: A release while the store is empty is ignored. The slot order and the count are unchanged, so the next stored frame is presented correctly.
- R9: A release and a valid pulse in the same cycle on a full store are both honoured. The head is freed, the new frame is stored behind the remaining one, and `overrun` is not raised.
- R10: `rx_active` becomes 1 the cycle after a start pulse and 0 the cycle after a valid or abort pulse. Start takes priority when the pulses coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_start | input | 1 | Pulse: a frame has begun on the bus |
| eng_valid | input | 1 | Pulse: the frame on the bus completed without error |
| eng_abort | input | 1 | Pulse: the frame in progress ended in error |
| eng_ext | input | 1 | Extended-identifier flag of the incoming frame |
| eng_rtr | input | 1 | Remote-request flag of the incoming frame |
| eng_dlc | input | 4 | Data length code of the incoming frame |
| eng_id | input | 29 | Identifier of the incoming frame |
| eng_data | input | 64 | Data bytes of the incoming frame |
| cpu_release | input | 1 | Pulse: free the presented slot |
| cpu_clr_overrun | input | 1 | Pulse: clear the overrun flag |
| rx_avail | output | 1 | At least one frame is held |
| overrun | output | 1 | Sticky flag: a completed frame was dropped |
| rx_active | output | 1 | A frame is currently being received |
| out_ext | output | 1 | Extended flag of the presented frame |
| out_rtr | output | 1 | Remote flag of the presented frame |
| out_dlc | output | 4 | Length code of the presented frame |
| out_id | output | 29 | Identifier of the presented frame |
| out_data | output | 64 | Data bytes of the presented frame |

## Verification
The store is exercised with several input patterns, and each one tells a different fault apart:
- A single frame, then two frames back to back. These separate a correct read pointer from one that presents the newest frame.
- A burst of three frames. This shows that the third frame is dropped rather than overwriting a held slot.
- A full store receiving an abort. This separates the valid-driven overrun from one raised on any frame end.
- A release with nothing held. This catches pointer or count underflow.
- Coincident pulses: release with valid on a full store, and clear with a drop. These pin down the two priority rules that a plain sequential test cannot reach.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int ID_W   = 29;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;

  typedef struct packed {
    logic              ext;
    logic              rtr;
    logic [DLC_W-1:0]  dlc;
    logic [ID_W-1:0]   id;
    logic [DATA_W-1:0] data;
  } rx_frame_t;
endpackage

// File: rtl/rxbuf_slots.sv
// Frame slot registers: one write port, one combinational read port.
module rxbuf_slots
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  rx_frame_t        wr_frame,
  input  logic [PTR_W-1:0] rd_idx,
  output rx_frame_t        rd_frame
);
  rx_frame_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_en && (wr_idx == PTR_W'(g)))
        slot_q[g] <= wr_frame;
    end
  end

  assign rd_frame = slot_q[rd_idx];
endmodule

// File: rtl/rxbuf_occupancy.sv
// Ring pointers and fill count.
// Release is resolved before admission, so a release frees room for a
// frame that completes in the same cycle.
module rxbuf_occupancy #(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             drop,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx,
  output logic             not_empty
);
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] wr_q, rd_q;
  logic             pop_ok;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign not_empty = (cnt_q != '0);
  assign pop_ok    = pop_req && not_empty;
  assign push_ok   = push_req && ((cnt_q < CNT_W'(DEPTH)) || pop_ok);
  assign drop      = push_req && !push_ok;
  assign wr_idx    = wr_q;
  assign rd_idx    = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else begin
      if (push_ok) wr_q <= step(wr_q);
      if (pop_ok)  rd_q <= step(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rxbuf_status.sv
// Sticky overrun flag and frame-in-progress indicator.
module rxbuf_status (
  input  logic clk,
  input  logic rst_n,
  input  logic drop,
  input  logic clr_ovr,
  input  logic frm_start,
  input  logic frm_end,
  output logic overrun,
  output logic rx_active
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overrun   <= 1'b0;
      rx_active <= 1'b0;
    end else begin
      if (drop)         overrun <= 1'b1;
      else if (clr_ovr) overrun <= 1'b0;

      if (frm_start)    rx_active <= 1'b1;
      else if (frm_end) rx_active <= 1'b0;
    end
  end
endmodule

// File: rtl/rxbuf_dual.sv
module rxbuf_dual
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_start,
  input  logic              eng_valid,
  input  logic              eng_abort,
  input  logic              eng_ext,
  input  logic              eng_rtr,
  input  logic [DLC_W-1:0]  eng_dlc,
  input  logic [ID_W-1:0]   eng_id,
  input  logic [DATA_W-1:0] eng_data,
  input  logic              cpu_release,
  input  logic              cpu_clr_overrun,
  output logic              rx_avail,
  output logic              overrun,
  output logic              rx_active,
  output logic              out_ext,
  output logic              out_rtr,
  output logic [DLC_W-1:0]  out_dlc,
  output logic [ID_W-1:0]   out_id,
  output logic [DATA_W-1:0] out_data
);
  rx_frame_t        in_frame, head_frame;
  logic             push_ok, drop;
  logic [PTR_W-1:0] wr_idx, rd_idx;

  always_comb begin
    in_frame.ext  = eng_ext;
    in_frame.rtr  = eng_rtr;
    in_frame.dlc  = eng_dlc;
    in_frame.id   = eng_id;
    in_frame.data = eng_data;
  end

  rxbuf_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (eng_valid),
    .pop_req   (cpu_release),
    .push_ok   (push_ok),
    .drop      (drop),
    .wr_idx    (wr_idx),
    .rd_idx    (rd_idx),
    .not_empty (rx_avail)
  );

  rxbuf_slots #(.DEPTH(DEPTH)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (push_ok),
    .wr_idx   (wr_idx),
    .wr_frame (in_frame),
    .rd_idx   (rd_idx),
    .rd_frame (head_frame)
  );

  rxbuf_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .drop      (drop),
    .clr_ovr   (cpu_clr_overrun),
    .frm_start (eng_start),
    .frm_end   (eng_valid | eng_abort),
    .overrun   (overrun),
    .rx_active (rx_active)
  );

  assign out_ext  = head_frame.ext;
  assign out_rtr  = head_frame.rtr;
  assign out_dlc  = head_frame.dlc;
  assign out_id   = head_frame.id;
  assign out_data = head_frame.data;
endmodule

// File: rtl/rxbuf_dual_chk.sv
module rxbuf_dual_chk
  import rxbuf_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            eng_start,
  input logic            eng_valid,
  input logic            eng_abort,
  input logic            cpu_release,
  input logic            cpu_clr_overrun,
  input logic            rx_avail,
  input logic            overrun,
  input logic            rx_active,
  input logic [ID_W-1:0] out_id
);
  // R2: a completed frame always leaves something to read
  p_valid_avail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |=> rx_avail);

  // R3/R5: without a release the presented frame cannot change
  p_head_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_avail && !cpu_release) |=> (rx_avail && $stable(out_id)));

  // R5: overrun rises only on a completed frame
  p_ovr_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(eng_valid));

  // R6: abort alone never raises overrun
  p_abort_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!overrun && eng_abort && !eng_valid) |=> !overrun);

  // R7: overrun is sticky until cleared
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !cpu_clr_overrun) |=> overrun);

  // R8: release on empty store changes nothing
  p_empty_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_avail && cpu_release && !eng_valid) |=> !rx_avail);

  // R10: start marks a frame in progress
  p_start_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> rx_active);

  // R10: frame end without a new start clears activity
  p_end_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((eng_valid || eng_abort) && !eng_start) |=> !rx_active);
endmodule

bind rxbuf_dual rxbuf_dual_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .eng_start       (eng_start),
  .eng_valid       (eng_valid),
  .eng_abort       (eng_abort),
  .cpu_release     (cpu_release),
  .cpu_clr_overrun (cpu_clr_overrun),
  .rx_avail        (rx_avail),
  .overrun         (overrun),
  .rx_active       (rx_active),
  .out_id          (out_id)
);

// File: tb/rxbuf_dual_bench.sv
module rxbuf_dual_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eng_start = 0, eng_valid = 0, eng_abort = 0;
  logic        eng_ext = 0, eng_rtr = 0;
  logic [3:0]  eng_dlc = '0;
  logic [28:0] eng_id = '0;
  logic [63:0] eng_data = '0;
  logic        cpu_release = 0, cpu_clr_overrun = 0;
  logic        rx_avail, overrun, rx_active, out_ext, out_rtr;
  logic [3:0]  out_dlc;
  logic [28:0] out_id;
  logic [63:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rxbuf_dual u_rxbuf_dual (
    .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_valid(eng_valid),
    .eng_abort(eng_abort), .eng_ext(eng_ext), .eng_rtr(eng_rtr),
    .eng_dlc(eng_dlc), .eng_id(eng_id), .eng_data(eng_data),
    .cpu_release(cpu_release), .cpu_clr_overrun(cpu_clr_overrun),
    .rx_avail(rx_avail), .overrun(overrun), .rx_active(rx_active),
    .out_ext(out_ext), .out_rtr(out_rtr), .out_dlc(out_dlc),
    .out_id(out_id), .out_data(out_data)
  );

  function automatic logic [63:0] data_of(input logic [28:0] id);
    return {id[15:0], ~id[15:0], id[31-3:0] ^ 29'h0abc_1234, 3'b101};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_head(input string req, input logic [28:0] id);
    chk(req, "out_id", 64'(out_id), 64'(id));
    chk(req, "out_data", out_data, data_of(id));
    chk(req, "out_dlc", 64'(out_dlc), 64'(id[3:0]));
    chk(req, "out_ext", 64'(out_ext), 64'(id[0]));
    chk(req, "out_rtr", 64'(out_rtr), 64'(id[1]));
  endtask

  // One cycle of stimulus; returns at the following negedge.
  task automatic cyc(input logic st, input logic vl, input logic ab,
                     input logic rel, input logic clr, input logic [28:0] id);
    @(negedge clk);
    eng_start = st; eng_valid = vl; eng_abort = ab;
    cpu_release = rel; cpu_clr_overrun = clr;
    eng_id = id; eng_data = data_of(id); eng_dlc = id[3:0];
    eng_ext = id[0]; eng_rtr = id[1];
    @(negedge clk);
    eng_start = 0; eng_valid = 0; eng_abort = 0;
    cpu_release = 0; cpu_clr_overrun = 0;
  endtask

  task automatic frame(input logic [28:0] id); cyc(0, 1, 0, 0, 0, id); endtask
  task automatic release_one();               cyc(0, 0, 0, 1, 0, '0); endtask
  task automatic clear_ovr();                 cyc(0, 0, 0, 0, 1, '0); endtask

  task automatic t_reset();
    chk("R1", "rx_avail", 64'(rx_avail), 0);
    chk("R1", "overrun", 64'(overrun), 0);
    chk("R1", "rx_active", 64'(rx_active), 0);
  endtask

  task automatic t_single();
    frame(29'h1234567);
    chk("R2", "rx_avail", 64'(rx_avail), 1);
    chk_head("R2", 29'h1234567);
    release_one();
    chk("R4", "rx_avail", 64'(rx_avail), 0);
  endtask

  task automatic t_order();
    frame(29'h0000aa1);
    frame(29'h1bbbbb2);
    chk_head("R3", 29'h0000aa1);
    release_one();
    chk("R3", "rx_avail", 64'(rx_avail), 1);
    chk_head("R3", 29'h1bbbbb2);
    release_one();
    chk("R4", "rx_avail", 64'(rx_avail), 0);
  endtask

  task automatic t_overrun();
    frame(29'h0111111);
    frame(29'h0222222);
    chk("R5", "overrun before drop", 64'(overrun), 0);
    frame(29'h0333333);
    chk("R5", "overrun", 64'(overrun), 1);
    chk_head("R5", 29'h0111111);
    release_one();
    chk_head("R5", 29'h0222222);
    release_one();
    chk("R5", "rx_avail after two", 64'(rx_avail), 0);
    chk("R7", "overrun sticky", 64'(overrun), 1);
    clear_ovr();
    chk("R7", "overrun cleared", 64'(overrun), 0);
  endtask

  task automatic t_abort_full();
    frame(29'h0444444);
    frame(29'h0555555);
    cyc(1, 0, 0, 0, 0, '0);
    chk("R10", "rx_active after start", 64'(rx_active), 1);
    cyc(0, 0, 1, 0, 0, 29'h0666666);
    chk("R6", "overrun after abort", 64'(overrun), 0);
    chk("R6", "rx_active after abort", 64'(rx_active), 0);
    chk_head("R6", 29'h0444444);
    release_one();
    chk_head("R6", 29'h0555555);
    release_one();
    chk("R6", "rx_avail", 64'(rx_avail), 0);
  endtask

  task automatic t_empty_release();
    release_one();
    release_one();
    chk("R8", "rx_avail", 64'(rx_avail), 0);
    frame(29'h0777777);
    chk_head("R8", 29'h0777777);
    release_one();
    chk("R8", "rx_avail after one", 64'(rx_avail), 0);
  endtask

  task automatic t_same_cycle();
    frame(29'h0888881);
    frame(29'h0999992);
    cyc(0, 1, 0, 1, 0, 29'h0aaaaa3);
    chk("R9", "overrun", 64'(overrun), 0);
    chk_head("R9", 29'h0999992);
    release_one();
    chk_head("R9", 29'h0aaaaa3);
    release_one();
    chk("R9", "rx_avail", 64'(rx_avail), 0);
  endtask

  task automatic t_clr_vs_set();
    frame(29'h0bbbbb4);
    frame(29'h0ccccc5);
    cyc(0, 1, 0, 0, 1, 29'h0ddddd6);
    chk("R7", "set wins over clear", 64'(overrun), 1);
    clear_ovr();
    chk("R7", "overrun cleared", 64'(overrun), 0);
    release_one();
    release_one();
    chk("R4", "rx_avail", 64'(rx_avail), 0);
  endtask

  task automatic t_active();
    cyc(1, 0, 0, 0, 0, '0);
    chk("R10", "rx_active set", 64'(rx_active), 1);
    frame(29'h0eeeee7);
    chk("R10", "rx_active cleared by valid", 64'(rx_active), 0);
    cyc(1, 1, 0, 0, 0, 29'h0fffff8);
    chk("R10", "start wins", 64'(rx_active), 1);
    cyc(0, 0, 1, 0, 0, '0);
    chk("R10", "cleared by abort", 64'(rx_active), 0);
    release_one();
    release_one();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_order();
    t_overrun();
    t_abort_full();
    t_empty_release();
    t_same_cycle();
    t_clr_vs_set();
    t_active();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule